// File: doc/BRIEF.md
# Mask-Driven Bit-Field Extract/Insert Unit

This unit carries out two byte-wide bit-field operations, and an 8-bit field mask selects the field for each. The position of the mask's lowest set bit sets the shift amount, so no separate shift operand exists. An extract command reads one memory byte, keeps only the bits under the mask and returns them right-aligned as a result byte. An insert command takes the low-order bits of a register byte, moves them up to the position of the mask and merges them into a memory byte. This is a read-modify-write, and every destination bit outside the mask keeps its value.

A command is given by a one-cycle start pulse that carries the operation, the mask, the register byte and the byte address. The unit then drives a simple synchronous memory port. That port holds a request until the memory answers with a ready. When the operation finishes, the unit gives a one-cycle done pulse. The extract result stays on its own output until a later extract replaces it. The unit has no condition-flag outputs, so it cannot disturb any flag state around it. An insert never changes the result output, and it does not change the register byte it was given.

Top module: `bfu_field_unit`

## Requirements
- R1: The extract result equals (mem_byte AND mask) shifted right by the index of the lowest set bit of the mask. For example, byte 0xA5 gives 0x09 with mask 0x3C, 0x0A with mask 0xF0 and 0x52 with mask 0xFE.
- R2: With a zero mask, extract returns 0x00, and insert still writes the destination byte back with its value unchanged.
- R3: Insert writes ((src << lowest_set_index(mask)) AND mask) OR (dest AND NOT mask). For example, src 0xA5 with mask 0x3C gives 0x14 into 0x00 and 0xD7 into 0xC3.
- R4: A single-bit mask tests or sets one bit. For byte 0xA5, mask 0x01 extracts 1 and mask 0x02 extracts 0. Inserting 0xA5 with mask 0x80 into 0x00 gives 0x80.
- R5: Extract makes exactly one memory read (mem_we=0) and no write. Insert makes exactly one read followed by exactly one write (mem_we=1), and both go to the commanded address.
- R6: While mem_req is high and mem_ready is low, mem_req, mem_we, mem_addr and mem_wdata keep their values into the next cycle.
- R7: cmd_start is ignored while busy is high. A command offered then causes no memory access and changes neither the result nor memory.
- R8: done is high for exactly one cycle per command. busy is high from the cycle after an accepted start through the done cycle, and it is low in the cycle after done.
- R9: res_data changes only when an extract completes. An insert leaves res_data unchanged.
- R10: Under synchronous active-high reset the unit is idle: busy, done, mem_req and mem_we are 0 and res_data is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle command strobe, accepted only when idle |
| cmd_op | input | 1 | Operation: 0 = extract, 1 = insert |
| cmd_mask | input | W | Field mask |
| cmd_reg | input | W | Register byte that supplies the field for insert |
| cmd_addr | input | ADDR_W | Byte address of the memory operand |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid in the cycle mem_ready is high |
| mem_ready | input | 1 | Memory completes the access at this clock edge |
| res_data | output | W | Right-aligned extract result, held between extracts |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A command is in progress |

## Verification
Properties inside the design check on every cycle the following: the hold of the memory request while it waits for ready, the absence of writes during extract, the single-cycle done pulse, that res_data stays stable outside extract completion, that a start offered while busy leaves the latched command untouched, and that the priority encoder's index and the merge's preserved bits are correct. Only the bench scenarios can show the actual field values against independent reference functions, the access counts and addresses of each operation, and the effect of the zero and single-bit masks. The same scenarios also show that an ignored start leaves other memory bytes untouched. They are run under random memory latency.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_MODIFY = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } bfu_state_t;

  typedef enum logic {
    OP_EXTRACT = 1'b0,
    OP_INSERT  = 1'b1
  } bfu_op_t;

endpackage

// File: rtl/bfu_lsb_enc.sv
module bfu_lsb_enc #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     mask,
  output logic [IDX_W-1:0] idx
);

  logic [W-1:0] below;
  logic [W-1:0] hit;

  assign below[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < W; g++) begin : g_chain
      assign below[g] = below[g-1] | mask[g-1];
    end
  endgenerate

  assign hit = mask & ~below;

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (hit[i]) idx = idx | IDX_W'(i);
    end
  end

  // R1: the index names a set bit with no set bit beneath it
  always_comb begin
    if (mask != '0) begin
      a_lsb_index_r1: assert (mask[idx] && ((mask & ((W'(1) << idx) - W'(1))) == '0))
        else $error("lowest-set index wrong");
    end
  end

endmodule

// File: rtl/bfu_field_alu.sv
module bfu_field_alu #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     mask,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     src,
  input  logic [W-1:0]     rd,
  output logic [W-1:0]     ext_val,
  output logic [W-1:0]     ins_val
);

  logic [W-1:0] kept;
  logic [W-1:0] placed;

  assign kept    = rd & mask;
  assign ext_val = kept >> idx;
  assign placed  = (src << idx) & mask;
  assign ins_val = placed | (rd & ~mask);

endmodule

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_op,
  input  logic [W-1:0]      cmd_mask,
  input  logic [W-1:0]      cmd_reg,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              mem_ready,
  input  logic [W-1:0]      mem_rdata,
  input  logic [W-1:0]      ext_val,
  input  logic [W-1:0]      ins_val,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      src_q,
  output logic [W-1:0]      rd_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [W-1:0]      mem_wdata,
  output logic [W-1:0]      res_data,
  output logic              done,
  output logic              busy
);

  bfu_state_t        state;
  bfu_op_t           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [W-1:0]      wdata_q;
  logic [W-1:0]      res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      op_q    <= OP_EXTRACT;
      addr_q  <= '0;
      mask_q  <= '0;
      src_q   <= '0;
      rd_q    <= '0;
      wdata_q <= '0;
      res_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_start) begin
            op_q   <= bfu_op_t'(cmd_op);
            addr_q <= cmd_addr;
            mask_q <= cmd_mask;
            src_q  <= cmd_reg;
            state  <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ready) begin
            rd_q  <= mem_rdata;
            state <= ST_MODIFY;
          end
        end
        ST_MODIFY: begin
          if (op_q == OP_EXTRACT) begin
            res_q <= ext_val;
            state <= ST_DONE;
          end else begin
            wdata_q <= ins_val;
            state   <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_ready) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign res_data  = res_q;
  assign done      = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);

  // R6: request and its fields hold until ready
  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)))
    else $error("request dropped or changed while waiting");

  // R5: writes occur only for insert
  p_no_ext_write_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (op_q == OP_INSERT))
    else $error("write during extract");

  // R8: done lasts one cycle and is followed by idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy))
    else $error("done not a single pulse");

  // R9: result changes only when an extract completes
  p_res_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(state == ST_MODIFY && op_q == OP_EXTRACT) |=> $stable(res_data))
    else $error("result changed outside extract completion");

  // R7: a start while busy leaves the latched command alone
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_start) |=> ($stable(addr_q) && $stable(mask_q) && $stable(src_q) && $stable(op_q)))
    else $error("command replaced while busy");

  // R3: merged byte keeps every destination bit outside the mask
  p_keep_unmasked_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_wdata & ~mask_q) == (rd_q & ~mask_q)))
    else $error("unmasked bits altered");

  // R2: zero mask gives zero extract value
  p_zero_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> (ext_val == '0))
    else $error("zero mask extract nonzero");

endmodule

// File: rtl/bfu_field_unit.sv
module bfu_field_unit #(
  parameter int W      = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_op,
  input  logic [W-1:0]      cmd_mask,
  input  logic [W-1:0]      cmd_reg,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [W-1:0]      mem_wdata,
  input  logic [W-1:0]      mem_rdata,
  input  logic              mem_ready,
  output logic [W-1:0]      res_data,
  output logic              done,
  output logic              busy
);

  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]     mask_q;
  logic [W-1:0]     src_q;
  logic [W-1:0]     rd_q;
  logic [IDX_W-1:0] lsb_idx;
  logic [W-1:0]     ext_val;
  logic [W-1:0]     ins_val;

  bfu_lsb_enc #(.W(W), .IDX_W(IDX_W)) u_enc (
    .mask (mask_q),
    .idx  (lsb_idx)
  );

  bfu_field_alu #(.W(W), .IDX_W(IDX_W)) u_alu (
    .mask    (mask_q),
    .idx     (lsb_idx),
    .src     (src_q),
    .rd      (rd_q),
    .ext_val (ext_val),
    .ins_val (ins_val)
  );

  bfu_ctrl #(.W(W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_start (cmd_start),
    .cmd_op    (cmd_op),
    .cmd_mask  (cmd_mask),
    .cmd_reg   (cmd_reg),
    .cmd_addr  (cmd_addr),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .ext_val   (ext_val),
    .ins_val   (ins_val),
    .mask_q    (mask_q),
    .src_q     (src_q),
    .rd_q      (rd_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .res_data  (res_data),
    .done      (done),
    .busy      (busy)
  );

endmodule

// File: tb/tb_bfu_field_unit.sv
`timescale 1ns/1ps
module tb_bfu_field_unit;

  localparam int W      = 8;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_start = 1'b0;
  logic              cmd_op = 1'b0;
  logic [W-1:0]      cmd_mask = '0;
  logic [W-1:0]      cmd_reg = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic              mem_req, mem_we, done, busy;
  logic [ADDR_W-1:0] mem_addr;
  logic [W-1:0]      mem_wdata, mem_rdata, res_data;
  logic              mem_ready = 1'b0;

  logic [W-1:0] mem     [DEPTH];
  logic [W-1:0] ref_mem [DEPTH];

  int errs = 0, checks = 0;
  int rd_cnt = 0, wr_cnt = 0, hold_err = 0;
  logic [ADDR_W-1:0] last_rd_addr, last_wr_addr;

  always #5 clk = ~clk;

  bfu_field_unit #(.W(W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_mask(cmd_mask), .cmd_reg(cmd_reg), .cmd_addr(cmd_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .res_data(res_data), .done(done), .busy(busy)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        last_wr_addr <= mem_addr;
      end else begin
        rd_cnt <= rd_cnt + 1;
        last_rd_addr <= mem_addr;
      end
    end
  end

  // memory ready with random latency; also watches request hold (R6)
  int lat = 0;
  logic was_wait = 1'b0;
  logic              s_we;
  logic [ADDR_W-1:0] s_addr;
  logic [W-1:0]      s_wdata;
  always @(negedge clk) begin
    if (was_wait && (!mem_req || mem_we != s_we || mem_addr != s_addr ||
                     (s_we && mem_wdata != s_wdata)))
      hold_err = hold_err + 1;
    if (mem_ready) begin
      mem_ready = 1'b0;
      lat = int'($urandom % 3);
    end else if (mem_req) begin
      if (lat == 0) mem_ready = 1'b1;
      else lat = lat - 1;
    end
    was_wait = mem_req && !mem_ready;
    s_we = mem_we; s_addr = mem_addr; s_wdata = mem_wdata;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int lsb_of(input logic [W-1:0] m);
    for (int i = 0; i < W; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic logic [W-1:0] ref_ext(input logic [W-1:0] b, input logic [W-1:0] m);
    return (b & m) >> lsb_of(m);
  endfunction

  function automatic logic [W-1:0] ref_ins(input logic [W-1:0] s, input logic [W-1:0] m,
                                           input logic [W-1:0] d);
    logic [W-1:0] sh;
    sh = s << lsb_of(m);
    return (sh & m) | (d & ~m);
  endfunction

  logic [W-1:0] prev_res;

  task automatic run_op(input bit op, input logic [W-1:0] m, input logic [W-1:0] s,
                        input logic [ADDR_W-1:0] a, input bit inject, input string tag);
    int rd0, wr0, n;
    logic [W-1:0] exp_v;
    logic [ADDR_W-1:0] alt;
    @(negedge clk);
    prev_res = res_data;
    rd0 = rd_cnt; wr0 = wr_cnt;
    cmd_start = 1'b1; cmd_op = op; cmd_mask = m; cmd_reg = s; cmd_addr = a;
    @(negedge clk);
    cmd_start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", busy, 1);
    n = 0;
    alt = a + 1'b1;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
      if (inject && n == 1) begin
        cmd_start = 1'b1; cmd_op = 1'b1; cmd_mask = 8'hFF; cmd_reg = ~mem[alt]; cmd_addr = alt;
      end else if (inject && n == 2) begin
        cmd_start = 1'b0;
      end
    end
    cmd_start = 1'b0;
    check(done == 1'b1, {tag, " R8 done seen"}, done, 1);
    check(rd_cnt - rd0 == 1 && last_rd_addr == a, {tag, " R5 one read at address"}, rd_cnt - rd0, 1);
    if (op == 1'b0) begin
      exp_v = ref_ext(ref_mem[a], m);
      check(res_data == exp_v, {tag, " R1 extract value"}, res_data, exp_v);
      check(wr_cnt == wr0, {tag, " R5 extract no write"}, wr_cnt - wr0, 0);
    end else begin
      exp_v = ref_ins(s, m, ref_mem[a]);
      ref_mem[a] = exp_v;
      check(mem[a] == exp_v, {tag, " R3 insert value"}, mem[a], exp_v);
      check(wr_cnt - wr0 == 1 && last_wr_addr == a, {tag, " R5 one write at address"}, wr_cnt - wr0, 1);
      check(res_data == prev_res, {tag, " R9 insert keeps result"}, res_data, prev_res);
    end
    if (inject) begin
      check(mem[alt] == ref_mem[alt], {tag, " R7 ignored start no write"}, mem[alt], ref_mem[alt]);
    end
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, {tag, " R8 done single pulse"}, {done, busy}, 0);
  endtask

  task automatic poke(input logic [ADDR_W-1:0] a, input logic [W-1:0] v);
    @(negedge clk);
    mem[a] = v; ref_mem[a] = v;
  endtask

  initial begin
    #2000000;
    errs++; checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1BF5));
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = W'($urandom);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && mem_req == 0 && mem_we == 0, "R10 reset idle",
          {busy, done, mem_req, mem_we}, 0);
    check(res_data == 8'h00, "R10 reset result", res_data, 0);
    rst = 1'b0;

    // directed extract on 0xA5
    poke(4'd5, 8'hA5);
    run_op(1'b0, 8'h3C, 8'h00, 4'd5, 1'b0, "R1 m3C");
    check(res_data == 8'h09, "R1 A5/3C literal", res_data, 8'h09);
    run_op(1'b0, 8'hF0, 8'h00, 4'd5, 1'b0, "R1 mF0");
    check(res_data == 8'h0A, "R1 A5/F0 literal", res_data, 8'h0A);
    run_op(1'b0, 8'hFE, 8'h00, 4'd5, 1'b0, "R1 mFE");
    check(res_data == 8'h52, "R1 A5/FE literal", res_data, 8'h52);
    run_op(1'b0, 8'h01, 8'h00, 4'd5, 1'b0, "R4 m01");
    check(res_data == 8'h01, "R4 bit0 test", res_data, 1);
    run_op(1'b0, 8'h02, 8'h00, 4'd5, 1'b0, "R4 m02");
    check(res_data == 8'h00, "R4 bit1 test", res_data, 0);
    run_op(1'b0, 8'h00, 8'h00, 4'd5, 1'b0, "R2 zero mask extract");
    check(res_data == 8'h00, "R2 zero mask result", res_data, 0);

    // directed insert
    poke(4'd6, 8'h00);
    run_op(1'b1, 8'h3C, 8'hA5, 4'd6, 1'b0, "R3 into 00");
    check(mem[6] == 8'h14, "R3 literal 14", mem[6], 8'h14);
    poke(4'd6, 8'hC3);
    run_op(1'b1, 8'h3C, 8'hA5, 4'd6, 1'b0, "R3 into C3");
    check(mem[6] == 8'hD7, "R3 literal D7", mem[6], 8'hD7);
    poke(4'd6, 8'h00);
    run_op(1'b1, 8'h80, 8'hA5, 4'd6, 1'b0, "R4 set bit7");
    check(mem[6] == 8'h80, "R4 literal 80", mem[6], 8'h80);
    poke(4'd7, 8'h5A);
    run_op(1'b1, 8'h00, 8'hFF, 4'd7, 1'b0, "R2 zero mask insert");
    check(mem[7] == 8'h5A, "R2 zero mask writes back", mem[7], 8'h5A);

    // start while busy is ignored
    run_op(1'b0, 8'h0F, 8'h00, 4'd3, 1'b1, "R7 during extract");
    run_op(1'b1, 8'hF0, 8'h3C, 4'd9, 1'b1, "R7 during insert");

    // random commands
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] m;
      int sel;
      sel = int'($urandom % 8);
      if (sel == 0) m = '0;
      else if (sel == 1) m = W'(1) << ($urandom % W);
      else m = W'($urandom);
      run_op(1'(($urandom) & 1), m, W'($urandom), ADDR_W'($urandom), (k % 17) == 0, "rand");
    end

    begin
      int bad;
      bad = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] != ref_mem[i]) bad++;
      check(bad == 0, "R7 memory image matches", bad, 0);
    end
    check(hold_err == 0, "R6 request held while waiting", hold_err, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule